// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block wraps a small synchronous circuit for structural test. Every state flip-flop of the circuit has a two-way selector on its data input. One setting strings all the flip-flops into a single serial shift register between `scan_in` and `scan_out`. The other setting loads the next state that a small example combinational core computes. The core's inputs are the flip-flop outputs and the applied primary inputs. Its outputs are the flip-flop data inputs and the primary outputs.

A sequencer runs the whole test procedure once `start` is pulsed. First it shifts in the state for the first pattern, raising `scan_en` for exactly one chain length of cycles. It then requests the primary inputs over a valid/request handshake and gives one functional capture clock. After that it shifts the captured state out while the tester shifts in the next pattern's state. The tester marks the final pattern with `pat_last`. That pattern's response is unloaded, and then the block raises `done`.

Top module: `scan_seq_top`

## Requirements
- R1: While reset is active and right after it, `scan_en`, `pat_req`, `resp_valid` and `done` are low and every chain flip-flop holds 0, so `scan_out` is 0.
- R2: On each clock where `scan_en` is high, flip-flop 0 takes `scan_in` and flip-flop i takes flip-flop i-1. `scan_out` always shows the last flip-flop (index NFF-1). Every shift phase lasts exactly NFF cycles.
- R3: When a shift phase ends, the block lowers `scan_en` and holds `pat_req` high until `pat_valid` is seen. Throughout that time the chain keeps its contents.
- R4: When `pat_req` and `pat_valid` are both high on a clock, `pat_pi` is captured. The next clock is the single functional capture clock. On it, each flip-flop loads the core's next-state bit, and no further capture follows.
- R5: One cycle after the capture clock, `resp_valid` pulses high for one cycle. At the same time `resp_po` shows the core's primary outputs, computed from the pre-capture state and the applied `pat_pi`.
- R6: After every capture, a shift phase of NFF cycles follows at once. It shifts the captured state out on `scan_out`, bit NFF-1 first, while it shifts the next pattern's state in. The bit wanted in flip-flop NFF-1 is sent first.
- R7: After the shift phase that follows a pattern accepted with `pat_last` high, `done` goes high and `scan_en` stays low. Both stay that way until `start` begins a new run.
- R8: The core computes next-state bit i as q[(i+1) mod NFF] XOR (pi[i mod NPI] AND NOT q[i]). It computes primary output j as q[j mod NFF] XOR pi[j mod NPI].
- R9: A `start` pulse while the sequencer is busy has no effect. The shift phase still ends after NFF cycles, and the sequencer moves on to request the primary inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a test run when the sequencer is idle or done |
| scan_in | input | 1 | Serial data into chain flip-flop 0 |
| pat_valid | input | 1 | Tester presents primary inputs |
| pat_pi | input | NPI | Primary input vector for the pattern |
| pat_last | input | 1 | Marks the final pattern of the run |
| scan_en | output | 1 | High during every shift phase |
| scan_out | output | 1 | Last chain flip-flop |
| pat_req | output | 1 | Sequencer waits for primary inputs |
| resp_po | output | NPO | Primary outputs observed at capture |
| resp_valid | output | 1 | One-cycle pulse qualifying `resp_po` |
| done | output | 1 | Run complete |

## Verification
A fault in the shift counter shows up at the ports on the very next phase change. `scan_en` falls one cycle early or late, and `pat_req` rises at the wrong moment. A broken chain link or capture path corrupts the unloaded response. The error appears on `scan_out` within NFF cycles of the capture, at the bit position of the faulty flip-flop. A wrong core function or a wrong latched input vector shows up in `resp_po` one cycle after capture, and also in the captured state that comes out in the following shift phase.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_APPLY,
      ST_CAPTURE,
      ST_DONE
   } seq_state_t;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic se,
   input  logic si,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= se ? si : d;
   end
endmodule

// File: rtl/scan_core.sv
module scan_core #(
   parameter int NFF = 6,
   parameter int NPI = 4,
   parameter int NPO = 3
) (
   input  logic [NFF-1:0] st,
   input  logic [NPI-1:0] pi,
   output logic [NFF-1:0] nxt,
   output logic [NPO-1:0] po
);
   for (genvar i = 0; i < NFF; i++) begin : g_nxt
      assign nxt[i] = st[(i+1) % NFF] ^ (pi[i % NPI] & ~st[i]);
   end
   for (genvar j = 0; j < NPO; j++) begin : g_po
      assign po[j] = st[j % NFF] ^ pi[j % NPI];
   end
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
   import scan_seq_pkg::*;
#(
   parameter int NFF = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic pat_valid,
   input  logic pat_last,
   output logic scan_en,
   output logic cap_en,
   output logic pat_req,
   output logic done
);
   localparam int CW = $clog2(NFF) + 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(NFF - 1);

   seq_state_t    state;
   logic [CW-1:0] cnt;
   logic          last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         last_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state  <= ST_SHIFT;
                  cnt    <= '0;
                  last_q <= 1'b0;
               end
            end
            ST_SHIFT: begin
               if (cnt == LAST_CNT) begin
                  cnt   <= '0;
                  state <= last_q ? ST_DONE : ST_APPLY;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_APPLY: begin
               if (pat_valid) begin
                  last_q <= pat_last;
                  state  <= ST_CAPTURE;
               end
            end
            ST_CAPTURE: state <= ST_SHIFT;
            default:    state <= ST_IDLE;
         endcase
      end
   end

   assign scan_en = (state == ST_SHIFT);
   assign cap_en  = (state == ST_CAPTURE);
   assign pat_req = (state == ST_APPLY);
   assign done    = (state == ST_DONE);

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_req && !pat_valid |=> pat_req);
   // R4
   accept_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_req && pat_valid |=> cap_en);
   // R4
   single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> !cap_en && scan_en);
   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done && !scan_en);
   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST_CNT);
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
   parameter int NFF = 6,
   parameter int NPI = 4,
   parameter int NPO = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           scan_in,
   input  logic           pat_valid,
   input  logic [NPI-1:0] pat_pi,
   input  logic           pat_last,
   output logic           scan_en,
   output logic           scan_out,
   output logic           pat_req,
   output logic [NPO-1:0] resp_po,
   output logic           resp_valid,
   output logic           done
);
   if (NFF < 2) begin : g_bad_nff
      $error("scan_seq_top: NFF must be at least 2");
   end
   if (NPI < 1 || NPO < 1) begin : g_bad_io
      $error("scan_seq_top: NPI and NPO must be at least 1");
   end

   logic           cap_en;
   logic           cell_en;
   logic [NFF-1:0] chain;
   logic [NFF-1:0] shift_src;
   logic [NFF-1:0] core_nxt;
   logic [NPO-1:0] core_po;
   logic [NPI-1:0] pi_q;

   scan_seq_fsm #(.NFF(NFF)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .pat_valid (pat_valid),
      .pat_last  (pat_last),
      .scan_en   (scan_en),
      .cap_en    (cap_en),
      .pat_req   (pat_req),
      .done      (done)
   );

   scan_core #(.NFF(NFF), .NPI(NPI), .NPO(NPO)) u_core (
      .st  (chain),
      .pi  (pi_q),
      .nxt (core_nxt),
      .po  (core_po)
   );

   assign cell_en = scan_en | cap_en;

   for (genvar i = 0; i < NFF; i++) begin : g_chain
      if (i == 0) begin : g_head
         assign shift_src[i] = scan_in;
      end else begin : g_link
         assign shift_src[i] = chain[i-1];
      end
      scan_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (cell_en),
         .se    (scan_en),
         .si    (shift_src[i]),
         .d     (core_nxt[i]),
         .q     (chain[i])
      );
   end

   assign scan_out = chain[NFF-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pi_q       <= '0;
         resp_po    <= '0;
         resp_valid <= 1'b0;
      end else begin
         if (pat_req && pat_valid) pi_q <= pat_pi;
         if (cap_en) resp_po <= core_po;
         resp_valid <= cap_en;
      end
   end

   // R2
   shift_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> chain[0] == $past(scan_in));
   // R2
   shift_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> chain[NFF-1:1] == $past(chain[NFF-2:0]));
   // R3
   chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en && !cap_en |=> $stable(chain));
   // R5
   resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> resp_valid);
   // R5
   resp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $past(cap_en));
endmodule

// File: tb/sim_scan_seq_top.sv
`timescale 1ns/1ps
module sim_scan_seq_top;
   localparam int NFF = 6;
   localparam int NPI = 4;
   localparam int NPO = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           scan_in = 1'b0;
   logic           pat_valid = 1'b0;
   logic [NPI-1:0] pat_pi = '0;
   logic           pat_last = 1'b0;
   logic           scan_en, scan_out, pat_req, resp_valid, done;
   logic [NPO-1:0] resp_po;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   logic [NFF-1:0] ch_model = '0;

   always #2.5 clk = ~clk;

   scan_seq_top #(.NFF(NFF), .NPI(NPI), .NPO(NPO)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .scan_in(scan_in),
      .pat_valid(pat_valid), .pat_pi(pat_pi), .pat_last(pat_last),
      .scan_en(scan_en), .scan_out(scan_out), .pat_req(pat_req),
      .resp_po(resp_po), .resp_valid(resp_valid), .done(done)
   );

   function automatic logic [NFF-1:0] g_nxt(input logic [NFF-1:0] q, input logic [NPI-1:0] p);
      logic [NFF-1:0] r;
      for (int i = 0; i < NFF; i++) r[i] = q[(i+1) % NFF] ^ (p[i % NPI] & ~q[i]);
      return r;
   endfunction

   function automatic logic [NPO-1:0] g_po(input logic [NFF-1:0] q, input logic [NPI-1:0] p);
      logic [NPO-1:0] r;
      for (int j = 0; j < NPO; j++) r[j] = q[j % NFF] ^ p[j % NPI];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_start();
      @(negedge clk); start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
   endtask

   // one shift phase; ch_model holds the expected chain before, load after
   task automatic shift_bits(input logic [NFF-1:0] load, input bit chk_po,
                             input logic [NPO-1:0] exp_po, input bit poke_start);
      logic [NFF-1:0] exp_unl = ch_model;
      for (int k = 0; k < NFF; k++) begin
         @(negedge clk);
         if (k == 0 && chk_po) begin
            chk("R5 resp_valid", resp_valid, 1);
            chk("R5 resp_po", resp_po, exp_po);
         end
         chk("R2 scan_en high", scan_en, 1);
         chk("R6 scan_out bit", scan_out, exp_unl[NFF-1-k]);
         scan_in = load[NFF-1-k];
         start = poke_start && (k == 1);
         @(posedge clk);
      end
      #1 start = 1'b0;
      ch_model = load;
   endtask

   task automatic apply_pat(input logic [NPI-1:0] p, input bit last, input int wait_n);
      logic [NPO-1:0] po_e;
      for (int w = 0; w < wait_n; w++) begin
         @(negedge clk);
         chk("R3 pat_req held", pat_req, 1);
         chk("R3 scan_en low", scan_en, 0);
         chk("R3 chain holds", scan_out, ch_model[NFF-1]);
         @(posedge clk);
      end
      @(negedge clk);
      chk("R3 pat_req", pat_req, 1);
      pat_valid = 1'b1; pat_pi = p; pat_last = last;
      @(posedge clk);
      @(negedge clk);
      pat_valid = 1'b0; pat_last = 1'b0;
      chk("R4 capture cycle no shift", scan_en, 0);
      chk("R4 capture cycle no req", pat_req, 0);
      @(posedge clk);
      po_e = g_po(ch_model, p);
      ch_model = g_nxt(ch_model, p);
      cur_po = po_e;
   endtask

   logic [NPO-1:0] cur_po;

   task automatic check_done();
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk("R7 done high", done, 1);
         chk("R7 scan_en low", scan_en, 0);
      end
      @(posedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 scan_en", scan_en, 0);
      chk("R1 pat_req", pat_req, 0);
      chk("R1 done", done, 0);
      chk("R1 resp_valid", resp_valid, 0);
      chk("R1 scan_out", scan_out, 0);
      rst_n = 1'b1;
      @(posedge clk);
      ch_model = '0;
   endtask

   task automatic t_single();
      do_start();
      shift_bits(6'b101101, 0, '0, 0);
      apply_pat(4'b0110, 1, 0);
      shift_bits('0, 1, cur_po, 0);   // R6 unload of captured state, R8 core
      check_done();
   endtask

   task automatic t_multi();
      logic [NFF-1:0] loads [3] = '{6'b110010, 6'b011111, 6'b000001};
      logic [NPI-1:0] pis   [3] = '{4'b1001, 4'b0000, 4'b1111};
      int             waits [3] = '{0, 3, 1};
      do_start();   // restart from done, R7
      shift_bits(loads[0], 0, '0, 0);
      for (int p = 0; p < 3; p++) begin
         apply_pat(pis[p], p == 2, waits[p]);
         shift_bits(p < 2 ? loads[p+1] : 6'b010101, 1, cur_po, 0);  // R6 overlap
      end
      check_done();
   endtask

   task automatic t_start_ignored();
      do_start();
      shift_bits(6'b100111, 0, '0, 1);
      @(negedge clk);
      chk("R9 shift ends after NFF", scan_en, 0);
      chk("R9 request follows", pat_req, 1);
      @(posedge clk);
      apply_pat(4'b1010, 1, 0);
      shift_bits(6'b001100, 1, cur_po, 0);
      check_done();
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_single();
      t_multi();
      t_start_ignored();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule